// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block decides when a small 8-bit microcontroller core may stop its clock, and when and how it comes back. The instruction decoder raises a one-cycle strobe when a sleep instruction executes. The block compares the interrupt flag vector with the per-source enable vector in that same cycle. If any enabled source is already pending, the sleep is dropped and behaves as a no-operation. Otherwise the block gates the core clock, holds the I/O outputs, clears the watchdog, clears the power-down status bit and sets the time-out status bit.

While the core is asleep, wake detection is purely combinational on the free-running clock. Three things can end sleep:

- An enabled interrupt. This wakes the core whatever the global interrupt enable is. The global enable only chooses whether the program counter logic resumes in line or also takes the interrupt vector after the next instruction.
- A watchdog time-out. This resumes execution and clears the time-out bit.
- An external reset request. This issues a core reset instead of a resume.

Every wake clears the watchdog.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After power-on reset, osc_en is 1, pd_flag is 1, to_flag is 1, io_hold is 0, and wdt_clr, resume_pulse, vector_req and core_reset are all 0.
- R2: A sleep strobe while running, in a cycle where the OR of (irq_flags AND irq_enables) is 1 and no external reset is requested, is a no-operation: osc_en stays 1, pd_flag and to_flag keep their values, and wdt_clr stays 0.
- R3: A sleep strobe while running with nothing pending and no external reset makes the next cycle show osc_en 0, io_hold 1, pd_flag 0, to_flag 1, and a one-cycle wdt_clr pulse.
- R4: While asleep, further sleep strobes and flags whose enable bit is 0 change nothing: osc_en stays 0, and no pulse output rises.
- R5: While asleep, any source with both flag and enable set wakes the core on the next clock. osc_en returns to 1, io_hold to 0, and resume_pulse and wdt_clr pulse for one cycle, whether gie is 0 or 1.
- R6: On a wake where an enabled interrupt is pending and gie is 1, vector_req pulses together with resume_pulse. With gie 0, or on a wake without a pending enabled interrupt, vector_req stays 0.
- R7: A wdt_timeout while asleep wakes the core with resume_pulse and wdt_clr, and clears to_flag. A wdt_timeout while running changes no output of this block.
- R8: ext_rst_req pulses core_reset on the next cycle in any state and takes priority over a sleep strobe in the same cycle. While asleep it wakes the core with a wdt_clr pulse and no resume_pulse. It leaves pd_flag and to_flag unchanged.
- R9: pd_flag never goes from 0 to 1 except through power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, never gated |
| rst_n | input | 1 | Active-low power-on reset |
| sleep_req | input | 1 | One-cycle strobe from the decoder when a sleep instruction executes |
| irq_flags | input | N_SRC | Per-source interrupt flags |
| irq_enables | input | N_SRC | Per-source interrupt enables |
| gie | input | 1 | Global interrupt enable |
| wdt_timeout | input | 1 | Watchdog time-out pulse |
| ext_rst_req | input | 1 | External reset request |
| osc_en | output | 1 | Core clock enable (0 while asleep) |
| io_hold | output | 1 | Hold I/O outputs at their pre-sleep state |
| wdt_clr | output | 1 | One-cycle clear for the watchdog and its prescaler |
| pd_flag | output | 1 | Power-down status bit (0 after a real sleep) |
| to_flag | output | 1 | Time-out status bit (0 after a watchdog wake) |
| resume_pulse | output | 1 | One-cycle request to continue at the instruction after sleep |
| vector_req | output | 1 | With resume_pulse: branch to the interrupt vector after that instruction |
| core_reset | output | 1 | One-cycle core reset request |

## Verification
The assertions check, on every cycle, the cycle-level contracts:

- a pending no-operation sleep keeps the clock running;
- a real sleep entry gates the clock with the status-bit update and watchdog clear;
- every clock re-enable carries a watchdog clear;
- a watchdog wake clears the time-out bit;
- vector_req only appears alongside resume_pulse after gie was set;
- pd_flag never rises outside reset.

Only the bench scenarios show that unenabled flags and repeated strobes leave a sleeping core untouched, and that external reset overrides a same-cycle sleep strobe. They also show that the status bits keep their values across a sequence of sleeps and wakes from different causes, and that a reset in the middle of a sleep restores the power-up state.

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
  parameter int N_SRC = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic [N_SRC-1:0] irq_flags,
  input  logic [N_SRC-1:0] irq_enables,
  input  logic             gie,
  input  logic             wdt_timeout,
  input  logic             ext_rst_req,
  output logic             osc_en,
  output logic             io_hold,
  output logic             wdt_clr,
  output logic             pd_flag,
  output logic             to_flag,
  output logic             resume_pulse,
  output logic             vector_req,
  output logic             core_reset
);

  logic asleep;
  logic irq_pending;
  logic wake_cond;

  assign irq_pending = |(irq_flags & irq_enables);
  assign wake_cond   = irq_pending | wdt_timeout;
  assign osc_en      = ~asleep;
  assign io_hold     = asleep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep       <= 1'b0;
      pd_flag      <= 1'b1;
      to_flag      <= 1'b1;
      wdt_clr      <= 1'b0;
      resume_pulse <= 1'b0;
      vector_req   <= 1'b0;
      core_reset   <= 1'b0;
    end else begin
      wdt_clr      <= 1'b0;
      resume_pulse <= 1'b0;
      vector_req   <= 1'b0;
      core_reset   <= 1'b0;
      if (ext_rst_req) begin
        core_reset <= 1'b1;
        if (asleep) begin
          asleep  <= 1'b0;
          wdt_clr <= 1'b1;
        end
      end else if (!asleep) begin
        if (sleep_req && !irq_pending) begin
          asleep  <= 1'b1;
          pd_flag <= 1'b0;
          to_flag <= 1'b1;
          wdt_clr <= 1'b1;
        end
      end else if (wake_cond) begin
        asleep       <= 1'b0;
        wdt_clr      <= 1'b1;
        resume_pulse <= 1'b1;
        vector_req   <= gie & irq_pending;
        if (wdt_timeout) to_flag <= 1'b0;
      end
    end
  end

endmodule

module sleep_wake_ctrl_chk #(
  parameter int N_SRC = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep_req,
  input logic [N_SRC-1:0] irq_flags,
  input logic [N_SRC-1:0] irq_enables,
  input logic             gie,
  input logic             wdt_timeout,
  input logic             ext_rst_req,
  input logic             osc_en,
  input logic             wdt_clr,
  input logic             pd_flag,
  input logic             to_flag,
  input logic             resume_pulse,
  input logic             vector_req
);

  AST_NOP_KEEPS_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en && sleep_req && !ext_rst_req && |(irq_flags & irq_enables)) |=> (osc_en && !wdt_clr)); // R2

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en && sleep_req && !ext_rst_req && !(|(irq_flags & irq_enables))) |=> (!osc_en && !pd_flag && to_flag && wdt_clr)); // R3

  AST_WAKE_CLEARS_WDT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> wdt_clr); // R5

  AST_VECTOR_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    vector_req |-> (resume_pulse && $past(gie))); // R6

  AST_WDT_WAKE_CLEARS_TO: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && wdt_timeout && !ext_rst_req) |=> (!to_flag && resume_pulse)); // R7

  AST_PD_NEVER_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(pd_flag)); // R9

endmodule

bind sleep_wake_ctrl sleep_wake_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .irq_flags(irq_flags),
  .irq_enables(irq_enables), .gie(gie), .wdt_timeout(wdt_timeout),
  .ext_rst_req(ext_rst_req), .osc_en(osc_en), .wdt_clr(wdt_clr),
  .pd_flag(pd_flag), .to_flag(to_flag), .resume_pulse(resume_pulse),
  .vector_req(vector_req)
);

// File: tb/sleep_wake_ctrl_bench.sv
module sleep_wake_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_SRC = 7;
  localparam int NV = 23;

  // {sleep, ext, wdt, gie, en[6:0], fl[6:0], exp{osc,wclr,pd,to,res,vec,rst,hold}}
  localparam logic [25:0] VEC [NV] = '{
    {4'b0000, 7'h00, 7'h00, 8'b10110000}, // 0  idle                  R1
    {4'b1000, 7'h01, 7'h01, 8'b10110000}, // 1  pending -> NOP        R2
    {4'b1000, 7'h00, 7'h01, 8'b01010001}, // 2  unenabled flag, sleep R3
    {4'b0000, 7'h00, 7'h00, 8'b00010001}, // 3  stay asleep           R4
    {4'b0000, 7'h00, 7'h02, 8'b00010001}, // 4  unenabled flag        R4
    {4'b0000, 7'h02, 7'h02, 8'b11011000}, // 5  irq wake, gie=0       R5
    {4'b0000, 7'h00, 7'h00, 8'b10010000}, // 6
    {4'b1000, 7'h00, 7'h00, 8'b01010001}, // 7  sleep                 R3
    {4'b0010, 7'h00, 7'h00, 8'b11001000}, // 8  wdt wake              R7
    {4'b0000, 7'h00, 7'h00, 8'b10000000}, // 9
    {4'b1000, 7'h00, 7'h00, 8'b01010001}, // 10 sleep sets to         R3
    {4'b0001, 7'h04, 7'h04, 8'b11011100}, // 11 irq wake, gie=1       R6
    {4'b0000, 7'h00, 7'h00, 8'b10010000}, // 12
    {4'b1000, 7'h00, 7'h00, 8'b01010001}, // 13 sleep
    {4'b1000, 7'h00, 7'h00, 8'b00010001}, // 14 repeated strobe       R4
    {4'b0100, 7'h00, 7'h00, 8'b11010010}, // 15 ext reset wake        R8
    {4'b0000, 7'h00, 7'h00, 8'b10010000}, // 16
    {4'b0010, 7'h00, 7'h00, 8'b10010000}, // 17 wdt while running     R7
    {4'b1100, 7'h00, 7'h00, 8'b10010010}, // 18 ext beats sleep       R8
    {4'b1000, 7'h40, 7'h7f, 8'b10010000}, // 19 NOP on top source     R2
    {4'b1000, 7'h00, 7'h00, 8'b01010001}, // 20 sleep
    {4'b0011, 7'h08, 7'h08, 8'b11001100}, // 21 wdt+irq, gie=1        R7
    {4'b0000, 7'h00, 7'h00, 8'b10000000}  // 22 pd stays low          R9
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, gie = 1'b0, wdt_timeout = 1'b0, ext_rst_req = 1'b0;
  logic [N_SRC-1:0] irq_flags = '0, irq_enables = '0;
  logic osc_en, io_hold, wdt_clr, pd_flag, to_flag, resume_pulse, vector_req, core_reset;
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_wake_ctrl #(.N_SRC(N_SRC)) u_sleep_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .irq_flags(irq_flags),
    .irq_enables(irq_enables), .gie(gie), .wdt_timeout(wdt_timeout),
    .ext_rst_req(ext_rst_req), .osc_en(osc_en), .io_hold(io_hold),
    .wdt_clr(wdt_clr), .pd_flag(pd_flag), .to_flag(to_flag),
    .resume_pulse(resume_pulse), .vector_req(vector_req), .core_reset(core_reset)
  );

  function automatic logic [7:0] outs();
    return {osc_en, wdt_clr, pd_flag, to_flag, resume_pulse, vector_req, core_reset, io_hold};
  endfunction

  task automatic check(input logic [7:0] exp, input string req);
    n_vec++;
    if (outs() !== exp) begin
      n_bad++;
      $display("FAIL %s: outputs %b expected %b", req, outs(), exp);
    end
  endtask

  task automatic drive(input logic [25:0] v);
    {sleep_req, ext_rst_req, wdt_timeout, gie} = v[25:22];
    irq_enables = v[21:15];
    irq_flags   = v[14:8];
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(8'b10110000, "R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check(8'b10110000, "R1 after reset release");

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(posedge clk);
      @(negedge clk);
      check(VEC[i][7:0], $sformatf("vector %0d", i));
    end

    drive(26'd0);
    @(negedge clk);
    check(8'b10000000, "R9 pd held low while idle");

    drive({4'b1000, 7'h00, 7'h00, 8'h00});
    @(posedge clk);
    @(negedge clk);
    drive(26'd0);
    check(8'b01010001, "R3 sleep before reset");
    rst_n = 1'b0;
    @(negedge clk);
    check(8'b10110000, "R1 reset during sleep");
    rst_n = 1'b1;
    @(negedge clk);
    check(8'b10110000, "R1 running after reset");
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 2000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule